// File: doc/BRIEF.md
# Statistics Counter Snapshot Unit

This block keeps a small bank of 64-bit event counters and lets software read them through a 32-bit word-addressed register port. Each counter takes two words on that port. A 64-bit value that is still counting can change between the read of one half and the read of the other, so the two halves may not belong to the same value. To give software a consistent pair, the block offers a freeze handshake. Software sets a request flag. The block copies every counter into a private shadow bank in one clock cycle, then raises a grant flag. While the grant stays up, counter reads come from the shadow bank. The counting itself never stops.

When software clears the request, the grant drops one cycle later and reads return the running values again. Each instance has its own request and grant. Two banks built from this block, for example one for receive and one for transmit, can therefore be frozen separately.

Top module: `stat_snapshot_top`

## Requirements
- R1: After a synchronous active-low reset, every counter, the request flag and the grant flag are zero. Every readable word reads as zero and `rd_valid_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` adds exactly one to counter k. When no snapshot is granted, a read of word address 2k returns bits 31:0 of counter k and a read of address 2k+1 returns bits 63:32.
- R3: A write to word address 0x45 loads the request flag from bit 2 of the write data. A read of 0x45 returns the request flag in bit 2 and zero in every other bit.
- R4: Bit 1 of word address 0x46 is the grant flag, and all its other bits read as zero. The grant equals the value the request flag had one cycle earlier.
- R5: The snapshot takes the counter values from the cycle in which the request is 1 and the grant is still 0. An increment that arrives in that cycle is left out of the snapshot. While the grant is 1, reads of every counter half return the snapshot values.
- R6: The counters keep incrementing while a snapshot is granted, and no event is lost. Once the grant drops, reads show every event, including those that arrived during the freeze.
- R7: Addresses that are neither counter words nor 0x45/0x46 read as zero. Writes to any address other than 0x45 change nothing that can be read, and the status word at 0x46 cannot be written.
- R8: Read data is registered. `rd_valid_o` is high, and `rd_data_o` holds the addressed word, in the cycle after the one in which `rd_en_i` was high. In every other cycle `rd_valid_o` is low.
- R9: The grant follows the level of the request. A request that is raised and cleared again before the grant is seen still ends with the grant at 0. A new request made after a release takes a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_CNT | One increment pulse per counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_data_o | output | DATA_W | Read data, registered |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |

## Verification
Some properties are checked by assertions on every cycle:
- a counter changes only in a cycle after one of its pulses;
- the shadow bank matches the live bank exactly one cycle after a capture, and holds still otherwise;
- the grant rises and falls only one cycle after the request does;
- read valid tracks the read strobe, and unmapped reads return zero.

Other behaviours need the bench's scenarios:
- an event that lands in the capture cycle is left out of the snapshot;
- the two halves read during a freeze stay constant while events keep arriving;
- every event counted during the freeze shows up after the release;
- a request that is raised and cleared at once settles back to no grant.

// File: rtl/stat_snap_pkg.sv
// Shared constants of the statistics snapshot unit: register addresses and
// the positions of the control and status bits that software decodes.
package stat_snap_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] SNAP_CTRL_ADDR = 8'h45;
    localparam logic [ADDR_W-1:0] SNAP_STAT_ADDR = 8'h46;
    localparam int REQ_BIT = 2;
    localparam int GNT_BIT = 1;
endpackage

// File: rtl/stat_live_bank.sv
// Live event counters. One counter per event input, each incremented by
// one on a single-cycle pulse. Assumes pulses never last longer than the
// events they stand for and that a counter never wraps within its lifetime.
module stat_live_bank #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_CNT-1:0] evt_i,
    output logic [CNT_W-1:0] live_o [NUM_CNT]
);
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        // Count event pulses for counter k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live_o[k] <= '0;
            else if (evt_i[k])
                live_o[k] <= live_o[k] + CNT_W'(1);
        end

        AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_i[k] |=> $stable(live_o[k])); // R2
        AST_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> live_o[k] != $past(live_o[k])); // R6
    end
endmodule

// File: rtl/stat_snap_ctrl.sv
// Request/grant handshake. Holds the request flag written by software,
// produces the grant one cycle after the request, and flags the capture
// cycle (request up, grant not yet up). Assumes one write port.
module stat_snap_ctrl
    import stat_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              req_o,
    output logic              grant_o,
    output logic              capture_o
);
    // Load the request flag from the control word write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_o <= 1'b0;
        else if (wr_en_i && wr_addr_i == SNAP_CTRL_ADDR)
            req_o <= wr_data_i[REQ_BIT];
    end

    // Grant trails the request level by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grant_o <= 1'b0;
        else
            grant_o <= req_o;
    end

    // Capture strobe: rising edge of the request seen against the grant.
    always_comb capture_o = req_o & ~grant_o;

    AST_GRANT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(req_o)); // R4
    AST_GRANT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_o) |-> !$past(req_o)); // R9
    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> !capture_o && grant_o); // R5
endmodule

// File: rtl/stat_shadow_bank.sv
// Shadow copies of all counters. On the capture strobe every copy is
// loaded from the live bank in the same edge; otherwise the copies hold.
// Assumes the strobe lasts one cycle per request.
module stat_shadow_bank #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [CNT_W-1:0] live_i   [NUM_CNT],
    output logic [CNT_W-1:0] shadow_o [NUM_CNT]
);
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_shd
        // Freeze counter k on the capture strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_o[k] <= '0;
            else if (capture_i)
                shadow_o[k] <= live_i[k];
        end

        AST_SNAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            capture_i |=> shadow_o[k] == $past(live_i[k])); // R5
        AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            !capture_i |=> $stable(shadow_o[k])); // R5
    end
endmodule

// File: rtl/stat_snapshot_top.sv
// Statistics snapshot unit top. Ties together live counters, shadow copies
// and the handshake, and serves a registered 32-bit word read port: live
// values when not granted, frozen values while granted. Assumes
// 2*NUM_CNT stays below the control address.
module stat_snapshot_top
    import stat_snap_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               rd_valid_o
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(2 * NUM_CNT);

    logic [CNT_W-1:0] live   [NUM_CNT];
    logic [CNT_W-1:0] shadow [NUM_CNT];
    logic req, grant, capture;
    logic [DATA_W-1:0] rd_word;
    logic [CNT_W-1:0]  pick;
    logic unmapped;

    stat_live_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) i_live (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .live_o(live));

    stat_snap_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .req_o(req), .grant_o(grant), .capture_o(capture));

    stat_shadow_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) i_shadow (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .live_i(live),
        .shadow_o(shadow));

    // Decode whether the read address hits nothing.
    always_comb unmapped = (rd_addr_i >= CNT_SPAN) && (rd_addr_i != SNAP_CTRL_ADDR)
                           && (rd_addr_i != SNAP_STAT_ADDR);

    // Select the addressed word from live or frozen values.
    always_comb begin
        rd_word = '0;
        pick    = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            pick = grant ? shadow[k] : live[k];
            if (rd_addr_i == ADDR_W'(2 * k))
                rd_word = pick[DATA_W-1:0];
            else if (rd_addr_i == ADDR_W'(2 * k + 1))
                rd_word = pick[CNT_W-1:DATA_W];
        end
        if (rd_addr_i == SNAP_CTRL_ADDR)
            rd_word[REQ_BIT] = req;
        if (rd_addr_i == SNAP_STAT_ADDR)
            rd_word[GNT_BIT] = grant;
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i)
                rd_data_o <= rd_word;
        end
    end

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R8
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && unmapped |=> rd_data_o == '0); // R7
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && rd_addr_i == SNAP_STAT_ADDR |=>
        rd_data_o == (DATA_W'($past(req, 2)) << GNT_BIT)); // R4
    AST_REQ_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(capture)); // R5
endmodule

// File: tb/test_stat_snapshot_top.sv
// Directed bench for the statistics snapshot unit: one task per scenario.
module test_stat_snapshot_top;
    import stat_snap_pkg::*;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic rd_valid;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit frozen = 1'b0;
    logic [63:0] exp_live [N];
    logic [63:0] exp_snap [N];

    stat_snapshot_top #(.NUM_CNT(N)) i_stat_snapshot_top (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid));

    always #4 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bump(logic [N-1:0] m);
        for (int k = 0; k < N; k++) if (m[k]) exp_live[k]++;
    endtask

    task automatic cycle(logic [N-1:0] m);
        evt = m;
        @(posedge clk); #1;
        evt = '0;
        bump(m);
    endtask

    task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Read one word while optionally pulsing events in the same cycle.
    task automatic read_chk(string req, logic [ADDR_W-1:0] a, logic [N-1:0] m,
                            logic [DATA_W-1:0] exp);
        rd_en = 1'b1; rd_addr = a; evt = m;
        @(posedge clk); #1;
        rd_en = 1'b0; evt = '0;
        bump(m);
        check("R8 valid", {63'd0, rd_valid}, 64'd1);
        check(req, {32'd0, rd_data}, {32'd0, exp});
    endtask

    // Read every counter half, expecting snapshot or live values.
    task automatic read_all(string req);
        for (int k = 0; k < N; k++) begin
            logic [63:0] v;
            v = frozen ? exp_snap[k] : exp_live[k];
            read_chk(req, ADDR_W'(2 * k), '0, v[31:0]);
            read_chk(req, ADDR_W'(2 * k + 1), '0, v[63:32]);
        end
    endtask

    task automatic t_reset();
        check("R1 valid low", {63'd0, rd_valid}, 64'd0);
        read_all("R1 counters zero");
        read_chk("R1 ctrl zero", SNAP_CTRL_ADDR, '0, 32'd0);
        read_chk("R1 status zero", SNAP_STAT_ADDR, '0, 32'd0);
        @(posedge clk); #1;
        check("R8 valid drops", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 3; i++) cycle(4'b0001);
        cycle(4'b1010); cycle(4'b1010);
        cycle(4'b1111);
        cycle(4'b0100); cycle(4'b0000);
        read_all("R2 live counts");
    endtask

    task automatic t_snapshot();
        do_write(SNAP_CTRL_ADDR, 32'h4);
        exp_snap = exp_live;
        // capture cycle: event here must not reach the snapshot
        read_chk("R4 grant latency", SNAP_STAT_ADDR, 4'b0011, 32'd0);
        read_chk("R4 grant set", SNAP_STAT_ADDR, '0, 32'h2);
        frozen = 1'b1;
        read_chk("R3 ctrl readback", SNAP_CTRL_ADDR, '0, 32'h4);
        read_all("R5 frozen reads");
        for (int i = 0; i < 5; i++) cycle(4'b1001);
        // halves of counter 0 read with events in between stay coherent
        read_chk("R5 coherent low", 8'h00, 4'b0001, exp_snap[0][31:0]);
        read_chk("R5 coherent high", 8'h01, 4'b0001, exp_snap[0][63:32]);
        do_write(SNAP_CTRL_ADDR, 32'h0);
        read_chk("R4 grant held one cycle", SNAP_STAT_ADDR, '0, 32'h2);
        frozen = 1'b0;
        read_chk("R4 grant released", SNAP_STAT_ADDR, '0, 32'd0);
        read_all("R6 live after release");
    endtask

    task automatic t_unmapped();
        read_chk("R7 addr 0x08", 8'h08, '0, 32'd0);
        read_chk("R7 addr 0x44", 8'h44, '0, 32'd0);
        read_chk("R7 addr 0x47", 8'h47, '0, 32'd0);
        read_chk("R7 addr 0xFF", 8'hFF, '0, 32'd0);
        do_write(8'h00, 32'hFFFF_FFFF);
        do_write(SNAP_STAT_ADDR, 32'hFFFF_FFFF);
        do_write(SNAP_CTRL_ADDR, 32'hFFFF_FFFB);
        @(posedge clk); #1;
        read_chk("R7 ctrl other bits", SNAP_CTRL_ADDR, '0, 32'd0);
        read_chk("R7 status not writable", SNAP_STAT_ADDR, '0, 32'd0);
        read_all("R7 counters untouched");
    endtask

    task automatic t_level();
        do_write(SNAP_CTRL_ADDR, 32'h4);
        do_write(SNAP_CTRL_ADDR, 32'h0);
        read_chk("R9 short request grant", SNAP_STAT_ADDR, '0, 32'h2);
        read_chk("R9 short request settles", SNAP_STAT_ADDR, '0, 32'd0);
        read_all("R9 live after short request");
        cycle(4'b0110);
        do_write(SNAP_CTRL_ADDR, 32'h4);
        exp_snap = exp_live;
        cycle(4'b1111);
        cycle(4'b0010);
        frozen = 1'b1;
        read_all("R9 fresh snapshot");
        do_write(SNAP_CTRL_ADDR, 32'h0);
        @(posedge clk); #1;
        frozen = 1'b0;
        read_all("R6 no lost events");
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin exp_live[k] = '0; exp_snap[k] = '0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_count();
        t_snapshot();
        t_unmapped();
        t_level();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule